// File: doc/BRIEF.md
# Manchester Word Transmitter with Back-to-Back Chaining

This block turns a 16-bit host word into one Manchester-coded frame on one of two serial buses. Each frame lasts twenty bit times at 1 Mbit/s: a three-bit-time sync pattern, sixteen data bits with the most significant bit first, and an odd-parity bit. The host picks the sync type and the target bus with each write. The block drives a true and a complement line for each bus. Both lines are low whenever that bus is not carrying a frame.

While a frame is going out, the block raises a chaining window flag. A word the host writes while that flag is high is held. It is then sent with no idle time as soon as the current frame ends, and it may go to either bus. Each bus has a disable input. A write aimed at a disabled bus is dropped. Bit timing comes from the clock frequency parameter, which by default gives six clock cycles per half bit.

Top module: `mwt_tx`

## Requirements
- R1: The first three bit times of a frame are the sync. With `wr_cmd_sync`=1 the true line is high for the first 1.5 bit times and low for the next 1.5. With `wr_cmd_sync`=0 this pattern is inverted.
- R2: `wr_bus_sel`=0 sends the word on bus A and `wr_bus_sel`=1 sends it on bus B. Both lines of the other bus stay low, and the two buses are never active at the same time.
- R3: After the sync, the 16 data bits follow with bit 15 first. Each bit takes two half bits: a 1 is high then low on the true line, and a 0 is low then high. While a bus is active its complement line is always the inverse of its true line.
- R4: The last bit time carries the parity bit, coded like a data bit. It makes the number of ones across the data and parity odd.
- R5: Number the half bits of a frame 0 to 39. `chain_window` is high exactly during half bits 7 through 36, which is 3.5 to 18.5 bit times after the frame starts. It is low at all other times, including when the block is idle.
- R6: A write accepted while `chain_window` is high starts its own frame on the clock edge that ends the current frame, with no idle cycle between the two. If several writes are accepted in one window, the last one is sent.
- R7: A write is dropped when the disable input of its selected bus (`tx_dis_a` or `tx_dis_b`) is 1 in the write cycle. This applies to writes made while idle and to writes made inside the window. A dropped write produces no activity on either bus.
- R8: After reset, and whenever no frame is in progress, all four line outputs and `chain_window` are low.
- R9: A write made while a frame is in progress but `chain_window` is low is ignored. The current frame ends normally and no further frame follows.
- R10: A frame starts on the clock edge that accepts an idle write. It lasts exactly 40 × HALF_TICKS clock cycles, where HALF_TICKS = CLK_HZ / (2 × BIT_HZ).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe, one cycle per word |
| wr_data | input | 16 | Word to transmit |
| wr_cmd_sync | input | 1 | 1 selects the command-type sync, 0 the data-type sync |
| wr_bus_sel | input | 1 | 0 selects bus A, 1 selects bus B |
| tx_dis_a | input | 1 | 1 blocks transmission on bus A |
| tx_dis_b | input | 1 | 1 blocks transmission on bus B |
| bus_a_p | output | 1 | Bus A true line |
| bus_a_n | output | 1 | Bus A complement line |
| bus_b_p | output | 1 | Bus B true line |
| bus_b_n | output | 1 | Bus B complement line |
| chain_window | output | 1 | High while a following word may be queued |

## Verification
The hardest cases to reach are writes that land exactly on the edges of the chaining window. The window spans 180 specific cycles inside a 240-cycle frame. A write one cycle early or one cycle late must be discarded, and a write on the first or last window cycle must chain with no gap. The stimulus places writes at cycle offsets 41, 42, 221 and 222 of a running frame, measured from the accepting edge. It also sends random words at random offsets inside the window, so that gap-free chains switch between buses and sync types.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

    localparam int DATA_W       = 16;
    localparam int SYNC_HALVES  = 6;
    localparam int DATA_HALVES  = 2 * DATA_W;
    localparam int FRAME_HALVES = SYNC_HALVES + DATA_HALVES + 2;
    localparam int HALF_W       = $clog2(FRAME_HALVES);
    localparam int WIN_FIRST    = 7;
    localparam int WIN_LAST     = FRAME_HALVES - 4;

    typedef logic [HALF_W-1:0] half_idx_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              cmd;
        logic              bus;
    } tx_word_t;

    // Line level of the true output for a given half bit of a frame.
    function automatic logic half_level(tx_word_t w, half_idx_t h);
        int   hi;
        int   bit_pos;
        logic b;
        logic lvl;
        hi = int'(h);
        if (hi < SYNC_HALVES) begin
            lvl = (hi < SYNC_HALVES / 2) ? w.cmd : ~w.cmd;
        end else if (hi < SYNC_HALVES + DATA_HALVES) begin
            bit_pos = DATA_W - 1 - (hi - SYNC_HALVES) / 2;
            b       = w.data[bit_pos];
            lvl     = ((hi - SYNC_HALVES) % 2 == 0) ? b : ~b;
        end else begin
            b   = ~(^w.data);
            lvl = (hi == FRAME_HALVES - 2) ? b : ~b;
        end
        return lvl;
    endfunction

endpackage

// File: rtl/mwt_halfbit_timer.sv
module mwt_halfbit_timer
    import mwt_pkg::*;
#(
    parameter int HALF_TICKS = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    output half_idx_t half_idx,
    output logic      frame_last
);
    localparam int TICK_W = $clog2(HALF_TICKS + 1);
    localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(HALF_TICKS - 1);
    localparam half_idx_t HALF_MAX = HALF_W'(FRAME_HALVES - 1);

    logic [TICK_W-1:0] tick_q;
    half_idx_t         half_q;
    logic              tick_wrap;

    assign tick_wrap = (tick_q == TICK_MAX);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tick_q <= '0;
            half_q <= '0;
        end else if (tick_wrap) begin
            tick_q <= '0;
            half_q <= (half_q == HALF_MAX) ? '0 : half_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign half_idx   = half_q;
    assign frame_last = run && tick_wrap && (half_q == HALF_MAX);
endmodule

// File: rtl/mwt_tx_ctrl.sv
module mwt_tx_ctrl
    import mwt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  tx_word_t in_word,
    input  logic     window,
    input  logic     frame_last,
    output logic     busy,
    output tx_word_t cur_word
);
    logic     busy_q;
    logic     pend_v_q;
    tx_word_t cur_q;
    tx_word_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            pend_v_q <= 1'b0;
            cur_q    <= '0;
            pend_q   <= '0;
        end else if (!busy_q) begin
            if (accept) begin
                cur_q  <= in_word;
                busy_q <= 1'b1;
            end
        end else begin
            if (window && accept) begin
                pend_q   <= in_word;
                pend_v_q <= 1'b1;
            end
            if (frame_last) begin
                if (pend_v_q) begin
                    cur_q    <= pend_q;
                    pend_v_q <= 1'b0;
                end else begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign cur_word = cur_q;
endmodule

// File: rtl/mwt_line_drv.sv
module mwt_line_drv #(
    parameter int NBUS = 2
) (
    input  logic                    active,
    input  logic                    level,
    input  logic [$clog2(NBUS)-1:0] bus_idx,
    output logic [NBUS-1:0]         line_p,
    output logic [NBUS-1:0]         line_n
);
    for (genvar g = 0; g < NBUS; g++) begin : g_bus
        logic on;
        assign on        = active && (int'(bus_idx) == g);
        assign line_p[g] = on & level;
        assign line_n[g] = on & ~level;
    end
endmodule

// File: rtl/mwt_tx.sv
module mwt_tx
    import mwt_pkg::*;
#(
    parameter int CLK_HZ = 12_000_000,
    parameter int BIT_HZ = 1_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        wr_cmd_sync,
    input  logic        wr_bus_sel,
    input  logic        tx_dis_a,
    input  logic        tx_dis_b,
    output logic        bus_a_p,
    output logic        bus_a_n,
    output logic        bus_b_p,
    output logic        bus_b_n,
    output logic        chain_window
);
    localparam int HALF_TICKS = CLK_HZ / (2 * BIT_HZ);

    tx_word_t  in_word;
    tx_word_t  cur_word;
    half_idx_t half_idx;
    logic      busy;
    logic      frame_last;
    logic      accept;
    logic      window;
    logic      level;
    logic [1:0] lp;
    logic [1:0] ln;

    assign in_word = '{data: wr_data, cmd: wr_cmd_sync, bus: wr_bus_sel};
    assign accept  = wr_en && !(wr_bus_sel ? tx_dis_b : tx_dis_a);
    assign window  = busy && (int'(half_idx) >= WIN_FIRST) && (int'(half_idx) <= WIN_LAST);
    assign level   = half_level(cur_word, half_idx);

    mwt_halfbit_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (busy),
        .half_idx   (half_idx),
        .frame_last (frame_last)
    );

    mwt_tx_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .in_word    (in_word),
        .window     (window),
        .frame_last (frame_last),
        .busy       (busy),
        .cur_word   (cur_word)
    );

    mwt_line_drv #(.NBUS(2)) u_drv (
        .active  (busy),
        .level   (level),
        .bus_idx (cur_word.bus),
        .line_p  (lp),
        .line_n  (ln)
    );

    assign bus_a_p      = lp[0];
    assign bus_a_n      = ln[0];
    assign bus_b_p      = lp[1];
    assign bus_b_n      = ln[1];
    assign chain_window = window;
endmodule

// File: rtl/mwt_tx_chk.sv
module mwt_tx_chk #(
    parameter int HALF_TICKS = 6
) (
    input logic clk,
    input logic rst,
    input logic wr_cmd_sync,
    input logic bus_a_p,
    input logic bus_a_n,
    input logic bus_b_p,
    input logic bus_b_n,
    input logic chain_window
);
    localparam int WIN_CYCLES = 30 * HALF_TICKS;

    logic act_a;
    logic act_b;
    logic act;
    logic [15:0] win_cnt;

    assign act_a = bus_a_p | bus_a_n;
    assign act_b = bus_b_p | bus_b_n;
    assign act   = act_a | act_b;

    always_ff @(posedge clk) begin
        if (rst) win_cnt <= '0;
        else     win_cnt <= chain_window ? win_cnt + 1'b1 : '0;
    end

    assert_one_bus_R2: assert property (@(posedge clk) disable iff (rst)
        !(act_a && act_b));

    assert_window_needs_frame_R5: assert property (@(posedge clk) disable iff (rst)
        chain_window |-> act);

    assert_window_length_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(chain_window) |-> (win_cnt == 16'(WIN_CYCLES)));

    assert_sync_first_half_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(act) |-> ((bus_a_p | bus_b_p) == $past(wr_cmd_sync)));

    assert_no_window_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !act |-> !chain_window);
endmodule

bind mwt_tx mwt_tx_chk #(.HALF_TICKS(HALF_TICKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_cmd_sync  (wr_cmd_sync),
    .bus_a_p      (bus_a_p),
    .bus_a_n      (bus_a_n),
    .bus_b_p      (bus_b_p),
    .bus_b_n      (bus_b_n),
    .chain_window (chain_window)
);

// File: tb/sim_mwt_tx.sv
`timescale 1ns/1ps
module sim_mwt_tx;
    localparam int HT     = 6;
    localparam int FRAME  = 40 * HT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_cmd_sync = 1'b0;
    logic        wr_bus_sel = 1'b0;
    logic        tx_dis_a = 1'b0;
    logic        tx_dis_b = 1'b0;
    logic        bus_a_p, bus_a_n, bus_b_p, bus_b_n, chain_window;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    mwt_tx u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_cmd_sync(wr_cmd_sync), .wr_bus_sel(wr_bus_sel),
        .tx_dis_a(tx_dis_a), .tx_dis_b(tx_dis_b),
        .bus_a_p(bus_a_p), .bus_a_n(bus_a_n), .bus_b_p(bus_b_p), .bus_b_n(bus_b_n),
        .chain_window(chain_window)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_level(logic [15:0] d, logic c, int h);
        logic b;
        if (h < 6) return (h < 3) ? c : !c;
        if (h < 38) begin
            b = d[15 - (h - 6) / 2];
            return ((h - 6) % 2 == 0) ? b : !b;
        end
        b = ~(^d);
        return (h == 38) ? b : !b;
    endfunction

    function automatic int lines_now();
        return int'({bus_a_p, bus_a_n, bus_b_p, bus_b_n});
    endfunction

    task automatic do_write(input logic [15:0] d, input logic c, input logic b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_cmd_sync = c; wr_bus_sel = b;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // Observes one frame, cycle 0 being the cycle after its starting edge.
    task automatic watch_frame(input logic [15:0] d, input logic c, input logic b,
                               input bit inj, input int inj_at,
                               input logic [15:0] id, input logic ic, input logic ib);
        int n_sync = 0, n_data = 0, n_par = 0, n_oth = 0, n_win = 0, n_edge = 0;
        logic sp, sn, e;
        for (int j = 0; j < FRAME; j++) begin
            @(negedge clk);
            if (inj && j == inj_at + 1) wr_en = 1'b0;
            if (inj && j == inj_at) begin
                wr_en = 1'b1; wr_data = id; wr_cmd_sync = ic; wr_bus_sel = ib;
            end
            sp = b ? bus_b_p : bus_a_p;
            sn = b ? bus_b_n : bus_a_n;
            if ((j == 0 || j == FRAME - 1) && !(sp | sn)) n_edge++;
            if (j % HT == 3) begin
                int h = j / HT;
                e = exp_level(d, c, h);
                if ((b ? (bus_a_p | bus_a_n) : (bus_b_p | bus_b_n)) != 1'b0) n_oth++;
                if (sp !== e || sn !== !e) begin
                    if (h < 6) n_sync++;
                    else if (h < 38) n_data++;
                    else n_par++;
                end
                if (chain_window !== (h >= 7 && h <= 36)) n_win++;
            end
        end
        check(n_sync == 0, "R1", "bad sync halves", n_sync, 0);
        check(n_data == 0, "R3", "bad data halves", n_data, 0);
        check(n_par == 0, "R4", "bad parity halves", n_par, 0);
        check(n_oth == 0, "R2", "other bus active", n_oth, 0);
        check(n_win == 0, "R5", "window mismatches", n_win, 0);
        check(n_edge == 0, "R10", "frame first/last cycle inactive", n_edge, 0);
    endtask

    task automatic expect_idle(input string req, input int cycles);
        int bad = 0;
        for (int j = 0; j < cycles; j++) begin
            @(negedge clk);
            if (lines_now() != 0 || chain_window !== 1'b0) bad++;
        end
        check(bad == 0, req, "activity while idle expected", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] d, nd;
        logic c, b, nc, nb;
        bit ch;
        void'($urandom(32'd4021));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R8: reset state
        @(negedge clk);
        check(lines_now() == 0 && chain_window == 1'b0, "R8", "outputs after reset",
              lines_now(), 0);

        // Directed: command sync on A, data sync on B
        do_write(16'hA5C3, 1'b1, 1'b0);
        watch_frame(16'hA5C3, 1'b1, 1'b0, 0, 0, '0, 1'b0, 1'b0);
        expect_idle("R8", 10);
        do_write(16'h0001, 1'b0, 1'b1);
        watch_frame(16'h0001, 1'b0, 1'b1, 0, 0, '0, 1'b0, 1'b0);
        expect_idle("R10", 10);

        // R6: chain on first window cycle, switching bus and sync
        do_write(16'hFFFF, 1'b0, 1'b0);
        watch_frame(16'hFFFF, 1'b0, 1'b0, 1, 42, 16'h1234, 1'b1, 1'b1);
        watch_frame(16'h1234, 1'b1, 1'b1, 0, 0, '0, 1'b0, 1'b0);
        expect_idle("R6", 10);
        // R6: chain on last window cycle
        do_write(16'h0000, 1'b1, 1'b1);
        watch_frame(16'h0000, 1'b1, 1'b1, 1, 221, 16'h8000, 1'b0, 1'b0);
        watch_frame(16'h8000, 1'b0, 1'b0, 0, 0, '0, 1'b0, 1'b0);
        expect_idle("R6", 10);

        // R9: one cycle before and one after the window are ignored
        do_write(16'h5A5A, 1'b1, 1'b0);
        watch_frame(16'h5A5A, 1'b1, 1'b0, 1, 41, 16'hDEAD, 1'b1, 1'b1);
        expect_idle("R9", 20);
        do_write(16'h3C3C, 1'b0, 1'b1);
        watch_frame(16'h3C3C, 1'b0, 1'b1, 1, 222, 16'hBEEF, 1'b1, 1'b0);
        expect_idle("R9", 20);

        // R7: disabled bus drops idle writes and in-window writes
        tx_dis_a = 1'b1;
        do_write(16'h7777, 1'b1, 1'b0);
        expect_idle("R7", FRAME + 10);
        do_write(16'h4321, 1'b1, 1'b1);
        watch_frame(16'h4321, 1'b1, 1'b1, 1, 100, 16'h9999, 1'b0, 1'b0);
        expect_idle("R7", 20);
        tx_dis_a = 1'b0;

        // Random words with random chaining inside the window
        d = 16'($urandom); c = 1'($urandom); b = 1'($urandom);
        do_write(d, c, b);
        for (int i = 0; i < 10; i++) begin
            ch = (i < 9) && ($urandom % 2 == 1);
            nd = 16'($urandom); nc = 1'($urandom); nb = 1'($urandom);
            watch_frame(d, c, b, ch, 42 + int'($urandom % 180), nd, nc, nb);
            if (!ch) begin
                expect_idle("R10", 5);
                if (i < 9) do_write(nd, nc, nb);
            end
            d = nd; c = nc; b = nb;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule